// File: doc/BRIEF.md
# Serial Channel Register Bus Slave with Vectored Acknowledge

This block is the byte-wide slave port that sits between a CPU bus and the register set of a serial channel. It decodes a sixteen-location address window. Every read or write finishes in the clock in which chip select is seen, with no wait states, because the channel runs on the CPU's own clock. The transmit, receive and interrupt-priority logic of the channel lie outside the block. The block sees that logic only as a few plain signals: a receive byte with its "data available" flag, a transmit byte with a load strobe, and a raw interrupt request.

The block keeps the channel's interrupt vector. When the interrupt controller grants the channel an acknowledge cycle, the block puts a vector number on the read-data lines. A two-state vector machine tracks whether software has programmed the vector. The machine starts in `VEC_UNSET`, where any acknowledge returns the spurious code 0x0F. It moves to `VEC_SET` on the first write to the vector location, and only a hardware reset brings it back to `VEC_UNSET`. Each cycle is sorted into one of four bus phases: `PH_IDLE` (no select, no acknowledge), `PH_RD`, `PH_WR` and `PH_IACK`. When select and acknowledge are both present, `PH_IACK` takes precedence.

Location map (4-bit address): 0x0 line mode (read/write), 0x1 status (read-only), 0x2 clock select (read/write), 0x3 auxiliary (read/write), 0x4 receive data on read and transmit data on write, 0x5 vector (read/write), 0x6 interrupt enable (read/write), 0x7 to 0xF reserved.

Top module: `sio_regbus`

## Requirements
- R1: `xfer_ack` is high in exactly those cycles in which `cs` or `iack` is high. This holds for every address, including reserved ones.
- R2: A read (`cs`=1, `rw`=1) returns its data on `rdata` in the same cycle. A read/write location returns the last byte written to it.
- R3: Reading a reserved location (0x7 to 0xF) returns 0x00. A write to a reserved location or to status (0x1) changes no location. Status reads as {6'b0, `chan_irq`, `rx_avail`}.
- R4: After reset, mode, clock select and interrupt enable read 0x00, the vector reads 0x0F, and bits 3:0 of the auxiliary location read 0.
- R5: Bits 7:4 of the auxiliary location keep their value through a hardware reset.
- R6: During an acknowledge (`iack`=1), `rdata` carries the vector in the same cycle. If the vector has not been written since reset, `rdata` carries 0x0F.
- R7: When `iack` and `cs` are high together, the register access is suppressed. No write lands, `rx_pop` stays low, and `rdata` carries the vector.
- R8: `irq` equals `chan_irq` AND bit 0 of the interrupt enable location. An acknowledge does not clear it.
- R9: `rx_pop` is high only in a cycle with `cs`=1, `rw`=1, address 0x4 and `iack`=0. That read returns `rx_byte`.
- R10: A write to 0x4 presents the byte on `tx_byte` and raises `tx_load` for exactly one cycle, in the cycle after the write.
- R11: With neither `cs` nor `iack` high, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared with the CPU |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| cs | input | 1 | Chip select for a register access |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register location |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data or acknowledge vector |
| xfer_ack | output | 1 | Transfer-complete strobe |
| iack | input | 1 | Acknowledge cycle won by this channel |
| chan_irq | input | 1 | Raw interrupt request from the channel |
| irq | output | 1 | Enabled interrupt request |
| rx_avail | input | 1 | Receive byte available |
| rx_byte | input | 8 | Receive byte from the channel |
| rx_pop | output | 1 | Consume the receive byte |
| tx_byte | output | 8 | Byte handed to the transmitter |
| tx_load | output | 1 | One-cycle transmit load strobe |

## Verification
The hardest case to reach is the auxiliary high nibble that survives reset. Its value before the first write is unknown, and a normal bus access cannot see it across a reset. The bench writes a known byte there, pulses `rst_n` in the middle of the run, and then reads the location to confirm that only the low nibble cleared. A second hard case is an acknowledge that overlaps a write to the vector location itself. The bench drives both together in the unprogrammed state and then checks that the spurious code still comes back.

// File: rtl/sio_regbus_pkg.sv
package sio_regbus_pkg;
    localparam int OFF_MODE   = 0;
    localparam int OFF_STAT   = 1;
    localparam int OFF_CLK    = 2;
    localparam int OFF_AUX    = 3;
    localparam int OFF_DATA   = 4;
    localparam int OFF_VEC    = 5;
    localparam int OFF_IEN    = 6;
    localparam int N_USED     = 7;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2,
        PH_IACK = 2'd3
    } bus_phase_e;

    typedef enum logic {
        VEC_UNSET = 1'b0,
        VEC_SET   = 1'b1
    } vec_state_e;
endpackage

// File: rtl/sio_bus_decode.sv
module sio_bus_decode
    import sio_regbus_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int N_LOC = 1 << ADDR_W
) (
    input  logic              cs,
    input  logic              rw,
    input  logic              iack,
    input  logic [ADDR_W-1:0] addr,
    output bus_phase_e        phase,
    output logic [N_LOC-1:0]  wr_sel,
    output logic [N_LOC-1:0]  rd_sel
);
    always_comb begin
        if (iack)
            phase = PH_IACK;
        else if (cs && rw)
            phase = PH_RD;
        else if (cs)
            phase = PH_WR;
        else
            phase = PH_IDLE;
    end

    for (genvar g = 0; g < N_LOC; g++) begin : g_sel
        assign wr_sel[g] = (phase == PH_WR) && (addr == ADDR_W'(g));
        assign rd_sel[g] = (phase == PH_RD) && (addr == ADDR_W'(g));
    end
endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
    import sio_regbus_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] VEC_INIT = 8'h0F,
    localparam int N_LOC = 1 << ADDR_W,
    localparam int HALF  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LOC-1:0]  wr_sel,
    input  logic [N_LOC-1:0]  rd_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_avail,
    input  logic              chan_irq,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] vec_q,
    output logic              ien_q,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_load
);
    logic [DATA_W-1:0] mode_q, clk_q, ien_byte_q;
    logic [HALF-1:0]   aux_hi_q;
    logic [DATA_W-HALF-1:0] aux_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= '0;
            clk_q      <= '0;
            ien_byte_q <= '0;
            vec_q      <= VEC_INIT;
            aux_lo_q   <= '0;
            tx_byte    <= '0;
            tx_load    <= 1'b0;
        end else begin
            tx_load <= wr_sel[OFF_DATA];
            if (wr_sel[OFF_MODE]) mode_q     <= wdata;
            if (wr_sel[OFF_CLK])  clk_q      <= wdata;
            if (wr_sel[OFF_IEN])  ien_byte_q <= wdata;
            if (wr_sel[OFF_VEC])  vec_q      <= wdata;
            if (wr_sel[OFF_AUX])  aux_lo_q   <= wdata[DATA_W-HALF-1:0];
            if (wr_sel[OFF_DATA]) tx_byte    <= wdata;
        end
    end

    // Upper auxiliary bits carry no reset.
    always_ff @(posedge clk) begin
        if (wr_sel[OFF_AUX]) aux_hi_q <= wdata[DATA_W-1:DATA_W-HALF];
    end

    assign ien_q = ien_byte_q[0];

    always_comb begin
        reg_rdata = '0;
        if (rd_sel[OFF_MODE]) reg_rdata = mode_q;
        if (rd_sel[OFF_STAT]) reg_rdata = {{(DATA_W-2){1'b0}}, chan_irq, rx_avail};
        if (rd_sel[OFF_CLK])  reg_rdata = clk_q;
        if (rd_sel[OFF_AUX])  reg_rdata = {aux_hi_q, aux_lo_q};
        if (rd_sel[OFF_DATA]) reg_rdata = rx_byte;
        if (rd_sel[OFF_VEC])  reg_rdata = vec_q;
        if (rd_sel[OFF_IEN])  reg_rdata = ien_byte_q;
    end
endmodule

// File: rtl/sio_vec_fsm.sv
module sio_vec_fsm
    import sio_regbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] SPURIOUS = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_wr,
    input  logic [DATA_W-1:0] vec_q,
    output logic [DATA_W-1:0] vector
);
    vec_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VEC_UNSET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        vector  = SPURIOUS;
        unique case (state_q)
            VEC_UNSET: begin
                vector = SPURIOUS;
                if (vec_wr) state_d = VEC_SET;
            end
            VEC_SET: begin
                vector = vec_q;
            end
        endcase
    end
endmodule

// File: rtl/sio_regbus.sv
module sio_regbus
    import sio_regbus_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] SPURIOUS = 8'h0F,
    localparam int N_LOC = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              xfer_ack,
    input  logic              iack,
    input  logic              chan_irq,
    output logic              irq,
    input  logic              rx_avail,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              rx_pop,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_load
);
    bus_phase_e        phase;
    logic [N_LOC-1:0]  wr_sel, rd_sel;
    logic [DATA_W-1:0] reg_rdata, vec_q, vector;
    logic              ien_q;

    sio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cs(cs), .rw(rw), .iack(iack), .addr(addr),
        .phase(phase), .wr_sel(wr_sel), .rd_sel(rd_sel)
    );

    sio_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_INIT(SPURIOUS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .rd_sel(rd_sel),
        .wdata(wdata), .rx_avail(rx_avail), .chan_irq(chan_irq),
        .rx_byte(rx_byte), .reg_rdata(reg_rdata), .vec_q(vec_q),
        .ien_q(ien_q), .tx_byte(tx_byte), .tx_load(tx_load)
    );

    sio_vec_fsm #(.DATA_W(DATA_W), .SPURIOUS(SPURIOUS)) u_vec (
        .clk(clk), .rst_n(rst_n), .vec_wr(wr_sel[OFF_VEC]),
        .vec_q(vec_q), .vector(vector)
    );

    always_comb begin
        unique case (phase)
            PH_IACK: rdata = vector;
            PH_RD:   rdata = reg_rdata;
            PH_WR,
            PH_IDLE: rdata = '0;
        endcase
    end

    assign xfer_ack = (phase != PH_IDLE);
    assign irq      = chan_irq && ien_q;
    assign rx_pop   = rd_sel[OFF_DATA];
endmodule

// File: rtl/sio_regbus_chk.sv
module sio_regbus_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              rw,
    input logic [ADDR_W-1:0] addr,
    input logic              iack,
    input logic [DATA_W-1:0] rdata,
    input logic              xfer_ack,
    input logic              chan_irq,
    input logic              irq,
    input logic              rx_pop,
    input logic              tx_load
);
    a_r1_ack_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        (cs || iack) |-> xfer_ack);
    a_r1_no_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !iack) |-> !xfer_ack);
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !iack) |-> (rdata == '0));
    a_r7_iack_blocks_pop: assert property (@(posedge clk) disable iff (!rst_n)
        iack |-> !rx_pop);
    a_r9_pop_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (cs && rw && !iack && addr == ADDR_W'(4)));
    a_r10_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(cs && !rw && !iack && addr == ADDR_W'(4)));
    a_r8_irq_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> chan_irq);
    a_r8_irq_survives_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && iack && $stable(chan_irq)) |=> (irq || !chan_irq || cs));
endmodule

bind sio_regbus sio_regbus_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .addr(addr), .iack(iack),
    .rdata(rdata), .xfer_ack(xfer_ack), .chan_irq(chan_irq), .irq(irq),
    .rx_pop(rx_pop), .tx_load(tx_load)
);

// File: tb/sio_regbus_tb.sv
`timescale 1ns/100ps
module sio_regbus_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rw = 1'b1, iack = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       xfer_ack, irq, rx_pop, tx_load;
    logic       chan_irq = 1'b0, rx_avail = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] tx_byte;

    int n_chk = 0, n_fail = 0;
    logic [7:0] model [16];
    logic       vec_prog;

    always #2.5 clk = ~clk;

    sio_regbus dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .addr(addr),
        .wdata(wdata), .rdata(rdata), .xfer_ack(xfer_ack), .iack(iack),
        .chan_irq(chan_irq), .irq(irq), .rx_avail(rx_avail),
        .rx_byte(rx_byte), .rx_pop(rx_pop), .tx_byte(tx_byte), .tx_load(tx_load)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int a);
        case (a)
            1:       return {6'b0, chan_irq, rx_avail};
            4:       return rx_byte;
            0, 2, 3, 5, 6: return model[a];
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit writable(input int a);
        return (a == 0) || (a == 2) || (a == 3) || (a == 5) || (a == 6);
    endfunction

    // Drive one cycle at the falling edge, sample 1 ns later.
    task automatic cyc(input logic c, input logic r, input logic [3:0] a,
                       input logic [7:0] d, input logic ia);
        @(negedge clk);
        cs = c; rw = r; addr = a; wdata = d; iack = ia;
        #1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        cs = 1'b0; iack = 1'b0; rw = 1'b1;
        #1;
    endtask

    task automatic model_reset();
        model[0] = 8'h00; model[2] = 8'h00; model[5] = 8'h0F; model[6] = 8'h00;
        model[3] = {model[3][7:4], 4'h0};
        vec_prog = 1'b0;
    endtask

    initial begin : watchdog
        #400us;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        model_reset();
        rx_byte = 8'h3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        go_idle();
        check("R11 idle rdata", rdata, 8'h00);
        check("R1 idle ack", xfer_ack, 1'b0);

        // Reset values and reserved reads (R4, R3, R2)
        for (int a = 0; a < 16; a++) begin
            cyc(1'b1, 1'b1, 4'(a), 8'h00, 1'b0);
            check("R1 ack on read", xfer_ack, 1'b1);
            if (a == 3) check("R4 aux low nibble reset", rdata & 8'h0F, 8'h00);
            else if (a >= 7) check("R3 reserved reads zero", rdata, 8'h00);
            else check("R4 reset read", rdata, exp_read(a));
            check("R9 pop only at data location", rx_pop, (a == 4));
        end
        go_idle();

        // Unprogrammed acknowledge (R6), overlapped with a vector write (R7)
        cyc(1'b0, 1'b1, 4'h0, 8'h00, 1'b1);
        check("R6 spurious vector", rdata, 8'h0F);
        check("R1 ack on iack", xfer_ack, 1'b1);
        cyc(1'b1, 1'b0, 4'h5, 8'h77, 1'b1);
        check("R7 iack wins over write", rdata, 8'h0F);
        go_idle();
        cyc(1'b0, 1'b1, 4'h0, 8'h00, 1'b1);
        check("R7 suppressed write left vector unset", rdata, 8'h0F);
        cyc(1'b1, 1'b1, 4'h4, 8'h00, 1'b1);
        check("R7 no pop during iack", rx_pop, 1'b0);
        go_idle();

        // Write sweep over every location (R2, R3, R10)
        for (int a = 0; a < 16; a++) begin
            logic [7:0] pat;
            pat = 8'((a * 37 + 11) & 8'hFF);
            cyc(1'b1, 1'b0, 4'(a), pat, 1'b0);
            check("R1 ack on write", xfer_ack, 1'b1);
            check("R11 write cycle rdata zero", rdata, 8'h00);
            if (writable(a)) model[a] = pat;
            if (a == 5) vec_prog = 1'b1;
            go_idle();
            check("R10 load strobe", tx_load, (a == 4));
            if (a == 4) check("R10 tx byte", tx_byte, pat);
        end
        go_idle();
        check("R10 load is one cycle", tx_load, 1'b0);

        // Readback sweep, twice with different channel inputs
        for (int pass = 0; pass < 2; pass++) begin
            rx_avail = pass[0]; chan_irq = ~pass[0]; rx_byte = 8'hA0 + 8'(pass);
            for (int a = 0; a < 16; a++) begin
                cyc(1'b1, 1'b1, 4'(a), 8'h00, 1'b0);
                if (a == 1) check("R3 status bits", rdata, exp_read(a));
                else if (a == 4) check("R9 receive byte", rdata, exp_read(a));
                else if (a >= 7) check("R3 reserved after write", rdata, 8'h00);
                else check("R2 readback", rdata, exp_read(a));
            end
        end
        go_idle();

        // Programmed vector and irq persistence (R6, R8)
        chan_irq = 1'b1;
        go_idle();
        check("R8 irq enabled", irq, model[6][0]);
        cyc(1'b0, 1'b1, 4'h0, 8'h00, 1'b1);
        check("R6 programmed vector", rdata, model[5]);
        go_idle();
        check("R8 irq held after ack", irq, model[6][0]);
        cyc(1'b1, 1'b0, 4'h6, 8'h00, 1'b0);
        go_idle();
        check("R8 irq masked", irq, 1'b0);
        model[6] = 8'h00;
        cyc(1'b1, 1'b0, 4'h6, 8'h01, 1'b0);
        model[6] = 8'h01;
        chan_irq = 1'b0;
        go_idle();
        check("R8 irq follows request", irq, 1'b0);

        // Writes to status do not land (R3)
        cyc(1'b1, 1'b0, 4'h1, 8'hFF, 1'b0);
        go_idle();
        cyc(1'b1, 1'b1, 4'h1, 8'h00, 1'b0);
        check("R3 status write dropped", rdata, exp_read(1));

        // Mid-run reset with known aux high nibble (R5, R4)
        cyc(1'b1, 1'b0, 4'h3, 8'hA5, 1'b0);
        model[3] = 8'hA5;
        go_idle();
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        go_idle();
        cyc(1'b1, 1'b1, 4'h3, 8'h00, 1'b0);
        check("R5 aux high nibble kept", rdata, 8'hA0);
        cyc(1'b1, 1'b1, 4'h5, 8'h00, 1'b0);
        check("R4 vector reset", rdata, 8'h0F);
        cyc(1'b1, 1'b1, 4'h0, 8'h00, 1'b0);
        check("R4 mode reset", rdata, 8'h00);
        cyc(1'b0, 1'b1, 4'h0, 8'h00, 1'b1);
        check("R6 spurious after reset", rdata, 8'h0F);
        go_idle();
        check("R11 idle after run", rdata, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule